// File: doc/BRIEF.md
# Flash Read Timing Controller

The block stands between a processor read port and a slow flash array. For every read it decides how many cycles the processor waits before the word arrives. A direct-mapped word cache in front of the array decides hit or miss, and a programmable read mode turns that outcome into a latency. Three latency rules are available. The fast rule adds nothing beyond the array access on a miss. The power-saving rule adds one extra cycle to every miss. The deterministic rule gives hits and misses the same latency.

The controller also manages the array's low-power state around system sleep. The array can enter low power when sleep starts and wake on the first read that needs it. It can instead wake when sleep ends. Automatic power reduction can also be switched off. Waking from low power costs a fixed delay, and a fast-wake option shortens it. All settings sit in one 32-bit control register, written and read over a simple register port. The processor side uses a valid/ready handshake with one read in flight.

Top module: `flash_rd_timer`

## Requirements
- R1: After reset the control register reads 0, `cpu_ready` and `fl_lowpwr` are low, and the cache holds no valid line, so the first read of any address is a miss.
- R2: Control register layout: wait states at bits 4:1, sleep mode at 9:8, fast wake at bit 11, read mode at 17:16, cache disable at bit 18. All other bits read 0.
- R3: A write that carries read mode 3 or sleep mode 2 leaves that field at its old value. The other fields of the same write still take effect.
- R4: In read mode 0 or 1, a cache hit completes one cycle after acceptance and returns the cached word.
- R5: A miss takes 1 + wait-state cycles in read mode 0 and 2 + wait-state cycles in read mode 1. It returns the array word and fills its cache line.
- R6: In read mode 2, hits and misses both take 1 + wait-state cycles.
- R7: With cache disable at 1, no read hits. Every change of the cache disable bit invalidates all lines.
- R8: The cache is direct mapped with 8 one-word lines indexed by address bits 2:0. A miss to a different address with the same index evicts the old word.
- R9: `cpu_ready` is high for exactly one cycle per read, with `cpu_rdata` valid in that cycle. The next read is accepted no earlier than the following cycle.
- R10: In sleep mode 0, `fl_lowpwr` rises on sleep entry and stays high after sleep ends. The first miss adds a wake delay of 4 cycles (1 cycle with fast wake at 1) and clears it. A hit neither waits nor wakes the array.
- R11: In sleep mode 1, `fl_lowpwr` rises on sleep entry and falls when sleep ends. A miss issued once the wake delay has elapsed pays no wake penalty.
- R12: In sleep mode 3, `fl_lowpwr` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register contents |
| cpu_valid | input | 1 | Read request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| sys_sleep | input | 1 | System sleep indication |
| fl_req | output | 1 | Array access in progress |
| fl_addr | output | ADDR_W | Array word address |
| fl_rdata | input | 32 | Array read data, combinational from `fl_addr` |
| fl_lowpwr | output | 1 | Array low-power state |

## Verification
The bench builds the block with a 6-bit word address and keeps the defaults for 8 cache lines and wake delays of 4 and 1. Only eight tags then compete for each line, so random reads produce a dense mix of hits, conflict evictions and refills. Frequent random control writes, some carrying reserved encodings or a toggled cache disable, reach every read mode and wait-state count together with flushes that land between reads.

// File: rtl/flrt_pkg.sv
package flrt_pkg;
  localparam logic [1:0] RM_FAST   = 2'd0;
  localparam logic [1:0] RM_LOWPWR = 2'd1;
  localparam logic [1:0] RM_FIXED  = 2'd2;
  localparam logic [1:0] RM_RSVD   = 2'd3;
  localparam logic [1:0] SM_ON_USE = 2'd0;
  localparam logic [1:0] SM_ON_END = 2'd1;
  localparam logic [1:0] SM_RSVD   = 2'd2;
  localparam logic [1:0] SM_OFF    = 2'd3;

  typedef struct packed {
    logic       cdis;
    logic [1:0] rmode;
    logic       fwup;
    logic [1:0] smode;
    logic [3:0] ws;
  } flrt_cfg_t;
endpackage

// File: rtl/flrt_cfg.sv
module flrt_cfg
  import flrt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [31:0] wdata,
  output flrt_cfg_t   cfg,
  output logic [31:0] rdata
);
  logic unused_bits;
  assign unused_bits = ^{wdata[31:19], wdata[15:12], wdata[10], wdata[7:5], wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr) begin
      cfg.ws   <= wdata[4:1];
      cfg.fwup <= wdata[11];
      cfg.cdis <= wdata[18];
      if (wdata[9:8] != SM_RSVD)   cfg.smode <= wdata[9:8];
      if (wdata[17:16] != RM_RSVD) cfg.rmode <= wdata[17:16];
    end
  end

  always_comb begin
    rdata        = '0;
    rdata[4:1]   = cfg.ws;
    rdata[9:8]   = cfg.smode;
    rdata[11]    = cfg.fwup;
    rdata[17:16] = cfg.rmode;
    rdata[18]    = cfg.cdis;
  end

  AST_RMODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cfg.rmode != RM_RSVD); // R3
  AST_SMODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cfg.smode != SM_RSVD); // R3
endmodule

// File: rtl/flrt_cache.sv
module flrt_cache #(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dis,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [31:0]       fill_data,
  output logic              hit,
  output logic [31:0]       hit_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = ADDR_W - IW;

  logic [LINES-1:0] valid;
  logic [TW-1:0]    tags [LINES];
  logic [31:0]      mem  [LINES];
  logic             dis_q;
  logic             flush;
  logic [IW-1:0]    lk_idx, f_idx;
  logic [TW-1:0]    lk_tag, f_tag;

  assign lk_idx = lk_addr[IW-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IW];
  assign f_idx  = fill_addr[IW-1:0];
  assign f_tag  = fill_addr[ADDR_W-1:IW];
  assign flush  = dis ^ dis_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      dis_q <= 1'b0;
    end else begin
      dis_q <= dis;
      if (flush)                valid        <= '0;
      else if (fill_en && !dis) valid[f_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !dis) begin
      tags[f_idx] <= f_tag;
      mem[f_idx]  <= fill_data;
    end
  end

  assign hit      = !dis && valid[lk_idx] && (tags[lk_idx] == lk_tag);
  assign hit_data = mem[lk_idx];

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid == '0)); // R7
endmodule

// File: rtl/flrt_seq.sv
module flrt_seq
  import flrt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LAT_W     = 8,
  parameter int WAKE_CYC  = 4,
  parameter int FWAKE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  flrt_cfg_t         cfg,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              sys_sleep,
  input  logic              hit,
  input  logic [31:0]       hit_data,
  input  logic [31:0]       fl_rdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_lowpwr,
  output logic              fill_en
);
  logic              busy, miss_q, sleep_q, lp;
  logic [LAT_W-1:0]  rem, warm, base, pen, lat, wdly, ws_x;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       hold_q;
  logic              accept, done, slp_rise, slp_fall;

  assign accept   = cpu_valid && !busy && !cpu_ready;
  assign done     = busy && (rem == LAT_W'(1));
  assign slp_rise = sys_sleep && !sleep_q;
  assign slp_fall = !sys_sleep && sleep_q;
  assign ws_x     = LAT_W'(cfg.ws);
  assign wdly     = cfg.fwup ? LAT_W'(FWAKE_CYC) : LAT_W'(WAKE_CYC);

  always_comb begin
    if (cfg.rmode == RM_FIXED)       base = ws_x + LAT_W'(1);
    else if (hit)                    base = LAT_W'(1);
    else if (cfg.rmode == RM_LOWPWR) base = ws_x + LAT_W'(2);
    else                             base = ws_x + LAT_W'(1);
    pen = hit ? '0 : (lp ? wdly : warm);
    lat = base + pen;
  end

  assign fl_addr   = busy ? addr_q : cpu_addr;
  assign fl_req    = (accept && !hit) || (busy && miss_q);
  assign fill_en   = (accept && !hit && lat == LAT_W'(1)) || (done && miss_q);
  assign fl_lowpwr = lp;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; miss_q <= 1'b0; rem <= '0; addr_q <= '0; hold_q <= '0;
      cpu_ready <= 1'b0; cpu_rdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      if (accept) begin
        addr_q <= cpu_addr;
        miss_q <= !hit;
        hold_q <= hit_data;
        if (lat == LAT_W'(1)) begin
          cpu_ready <= 1'b1;
          cpu_rdata <= hit ? hit_data : fl_rdata;
        end else begin
          busy <= 1'b1;
          rem  <= lat - LAT_W'(1);
        end
      end else if (done) begin
        busy      <= 1'b0;
        cpu_ready <= 1'b1;
        cpu_rdata <= miss_q ? fl_rdata : hold_q;
      end else if (busy) begin
        rem <= rem - LAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0; lp <= 1'b0; warm <= '0;
    end else begin
      sleep_q <= sys_sleep;
      if (warm != '0) warm <= warm - LAT_W'(1);
      if (slp_rise && cfg.smode != SM_OFF) begin
        lp <= 1'b1;
      end else if (slp_fall && cfg.smode == SM_ON_END && lp) begin
        lp   <= 1'b0;
        warm <= wdly;
      end else if (accept && !hit && lp) begin
        lp <= 1'b0;
      end
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R9
  AST_HIT_FAST: assert property (@(posedge clk) disable iff (rst)
    (accept && hit && cfg.rmode != RM_FIXED) |=> cpu_ready); // R4
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit && lp && !slp_rise) |=> !lp); // R10
  AST_LP_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg.smode == SM_OFF && !lp) |=> !lp); // R12
endmodule

// File: rtl/flash_rd_timer.sv
module flash_rd_timer #(
  parameter int ADDR_W    = 12,
  parameter int LINES     = 8,
  parameter int LAT_W     = 8,
  parameter int WAKE_CYC  = 4,
  parameter int FWAKE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  input  logic              sys_sleep,
  output logic              fl_req,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [31:0]       fl_rdata,
  output logic              fl_lowpwr
);
  flrt_pkg::flrt_cfg_t cfg;
  logic        hit, fill_en;
  logic [31:0] hit_data;

  flrt_cfg u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .cfg(cfg), .rdata(reg_rdata)
  );

  flrt_cache #(.ADDR_W(ADDR_W), .LINES(LINES)) u_cache (
    .clk(clk), .rst(rst), .dis(cfg.cdis), .lk_addr(cpu_addr),
    .fill_en(fill_en), .fill_addr(fl_addr), .fill_data(fl_rdata),
    .hit(hit), .hit_data(hit_data)
  );

  flrt_seq #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .WAKE_CYC(WAKE_CYC),
             .FWAKE_CYC(FWAKE_CYC)) u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .cpu_valid(cpu_valid),
    .cpu_addr(cpu_addr), .sys_sleep(sys_sleep), .hit(hit),
    .hit_data(hit_data), .fl_rdata(fl_rdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_lowpwr(fl_lowpwr), .fill_en(fill_en)
  );
endmodule

// File: tb/flash_rd_timer_tb.sv
module flash_rd_timer_tb;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cpu_valid = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic cpu_ready;
  logic [31:0] cpu_rdata;
  logic sys_sleep = 1'b0;
  logic fl_req, fl_lowpwr;
  logic [AW-1:0] fl_addr;
  logic [31:0] fl_rdata;

  always #4 clk = ~clk;

  function automatic logic [31:0] fdata(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction
  assign fl_rdata = fdata(fl_addr);

  flash_rd_timer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .sys_sleep(sys_sleep),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata),
    .fl_lowpwr(fl_lowpwr)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [3:0] m_ws = 0;
  logic [1:0] m_rm = 0, m_sm = 0;
  logic m_fw = 0, m_cd = 0, m_lp = 0;
  logic [7:0] m_v = '0;
  logic [2:0] m_t [8];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_reg();
    logic [31:0] r = '0;
    r[4:1] = m_ws; r[9:8] = m_sm; r[11] = m_fw; r[17:16] = m_rm; r[18] = m_cd;
    return r;
  endfunction

  task automatic reg_write(input logic [31:0] w, input string req);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
    m_ws = w[4:1]; m_fw = w[11];
    if (w[18] != m_cd) m_v = '0;
    m_cd = w[18];
    if (w[9:8] != 2'd2)   m_sm = w[9:8];
    if (w[17:16] != 2'd3) m_rm = w[17:16];
    check(reg_rdata == m_reg(), req, reg_rdata, m_reg());
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    bit hit;
    int exp_lat, lat;
    hit = !m_cd && m_v[a[2:0]] && (m_t[a[2:0]] == a[5:3]);
    if (m_rm == 2'd2)  exp_lat = 1 + int'(m_ws);
    else if (hit)      exp_lat = 1;
    else               exp_lat = 1 + int'(m_ws) + ((m_rm == 2'd1) ? 1 : 0);
    if (!hit && m_lp) begin
      exp_lat += m_fw ? 1 : 4;
      m_lp = 1'b0;
    end
    if (!hit && !m_cd) begin
      m_v[a[2:0]] = 1'b1;
      m_t[a[2:0]] = a[5:3];
    end
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a;
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!cpu_ready && lat < 60);
    cpu_valid = 1'b0;
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    check(cpu_rdata == fdata(a), {req, " data"}, cpu_rdata, fdata(a));
    @(negedge clk);
    check(!cpu_ready, "R9 ready pulse", cpu_ready, 0);
  endtask

  task automatic set_sleep(input logic v, input string req);
    @(negedge clk);
    if (v && !sys_sleep && m_sm != 2'd3) m_lp = 1'b1;
    if (!v && sys_sleep && m_sm == 2'd1) m_lp = 1'b0;
    sys_sleep = v;
    @(negedge clk);
    check(fl_lowpwr == m_lp, req, fl_lowpwr, m_lp);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 32'd0, "R1 reg reset", reg_rdata, 0);
    check(!cpu_ready, "R1 ready reset", cpu_ready, 0);
    check(!fl_lowpwr, "R1 lowpwr reset", fl_lowpwr, 0);
    do_read(6'd9, "R1 first read misses");

    // R2 layout, R3 reserved encodings
    reg_write(32'hFFFF_FFFF, "R2 R3 all ones");
    reg_write(32'h0002_0204, "R2 fields");
    reg_write(32'h0003_0200, "R3 reserved ignored");

    // R4/R5/R8 directed
    reg_write(32'h0000_0004, "R5 mode0 ws2");
    do_read(6'd5, "R5 miss mode0");
    do_read(6'd5, "R4 hit mode0");
    do_read(6'd13, "R8 conflict miss");
    do_read(6'd5, "R8 evicted refetch");
    reg_write(32'h0001_0006, "R5 mode1 ws3");
    do_read(6'd21, "R5 miss mode1");
    do_read(6'd21, "R4 hit mode1");
    reg_write(32'h0002_0006, "R6 mode2 ws3");
    do_read(6'd21, "R6 hit fixed");
    do_read(6'd30, "R6 miss fixed");
    reg_write(32'h0004_0000, "R7 disable");
    do_read(6'd30, "R7 disabled miss");
    do_read(6'd30, "R7 disabled miss again");
    reg_write(32'h0000_0000, "R7 reenable flush");
    do_read(6'd30, "R7 flushed miss");
    do_read(6'd30, "R4 refilled hit");

    // random phase
    for (int n = 0; n < 400; n++) begin
      if (n % 15 == 0) begin
        w = '0;
        w[4:1] = 4'($urandom_range(0, 15));
        w[9:8] = 2'($urandom_range(0, 3));
        w[11] = 1'($urandom_range(0, 1));
        w[17:16] = 2'($urandom_range(0, 3));
        w[18] = ($urandom_range(0, 3) == 0);
        w[31:19] = 13'($urandom);
        reg_write(w, "R3 random write");
      end
      do_read(AW'($urandom_range(0, 63)), "R5 R6 random read");
    end

    // sleep mode 0 (R10)
    reg_write(32'h0000_0002, "R10 setup ws1");
    do_read(6'd3, "R10 fill line");
    set_sleep(1'b1, "R10 lowpwr on entry");
    set_sleep(1'b0, "R10 lowpwr held after sleep");
    repeat (3) @(negedge clk);
    check(fl_lowpwr == 1'b1, "R10 lowpwr still held", fl_lowpwr, 1);
    do_read(6'd3, "R10 hit no wake");
    check(fl_lowpwr == 1'b1, "R10 hit keeps lowpwr", fl_lowpwr, 1);
    do_read(6'd4, "R10 miss wake slow");
    check(fl_lowpwr == 1'b0, "R10 woken", fl_lowpwr, 0);
    reg_write(32'h0000_0802, "R10 fast wake");
    set_sleep(1'b1, "R10 lowpwr entry fast");
    set_sleep(1'b0, "R10 held fast");
    do_read(6'd44, "R10 miss wake fast");

    // sleep mode 1 (R11)
    reg_write(32'h0000_0102, "R11 setup");
    set_sleep(1'b1, "R11 lowpwr on entry");
    set_sleep(1'b0, "R11 lowpwr off at end");
    repeat (8) @(negedge clk);
    do_read(6'd52, "R11 miss no penalty");

    // sleep mode 3 (R12)
    reg_write(32'h0000_0302, "R12 setup");
    set_sleep(1'b1, "R12 no lowpwr");
    repeat (4) @(negedge clk);
    check(fl_lowpwr == 1'b0, "R12 no lowpwr in sleep", fl_lowpwr, 0);
    set_sleep(1'b0, "R12 no lowpwr after");
    do_read(6'd60, "R12 miss plain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule